// File: doc/BRIEF.md
# Conversion-Aware Serial Clock Gate

This block takes a serial clock that runs all the time and lets through only one short burst of pulses per conversion of a high-resolution serial ADC. Outside that burst the ADC clock pin is held low. No clock edges then reach the converter while it resolves its low-order bits, so the clock cannot couple into it at that point. Alongside the burst the block drives an active-low frame signal to the serial port. The frame is low for exactly as long as the gate is open, so the port captures only the transferred bits.

The converter's busy flag (low while converting) sets when the burst happens. There are two read modes. In read-during mode the burst starts when a conversion begins, so the previous result is read in the first part of the new conversion. In read-after mode the burst starts when a conversion completes; this gives less throughput. All state changes on the falling edge of the incoming clock. The gated clock is the incoming clock ANDed with a registered enable, so every pulse that passes is a full high phase.

Top module: `sclk_burst_gate`

## Requirements
- R1: While `rst_n` is low, `adc_clk` stays low and `frame_n` stays high, whatever the other inputs do. The reset takes effect at once, without a clock edge.
- R2: With `read_after` = 0, while `busy_n` is high the gate stays closed: no `adc_clk` pulses and `frame_n` high.
- R3: With `read_after` = 0, the first falling edge of `clk_in` that samples `busy_n` low opens the gate. The next `clk_in` high phase is the first passed pulse.
- R4: Per active interval the block passes at most PULSES pulses (default 16). The gate closes on the falling edge that ends pulse number PULSES and stays closed for the rest of the interval.
- R5: `frame_n` is low exactly while the gate is open. It goes low on the edge that opens the gate and high on the edge that closes it.
- R6: If the active interval ends early, the next falling edge closes the gate and clears the pulse counter. An interval of L sampled falling edges passes min(L, PULSES) pulses, and the next interval gets a full fresh burst.
- R7: With `read_after` = 1, the roles of the two `busy_n` levels swap. The burst is keyed to `busy_n` being high (after a conversion completes), and no pulses pass while `busy_n` is low.
- R8: Every `adc_clk` high phase outside reset is exactly one full `clk_in` high phase. There are no shortened or glitch pulses.
- R9: After `rst_n` is released while the selected active level of `busy_n` is present, a full burst of PULSES pulses starts at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Free-running serial clock from the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_n | input | 1 | Converter busy flag, low while a conversion is in progress |
| read_after | input | 1 | Read mode: 0 = burst at conversion start, 1 = burst after conversion completes |
| adc_clk | output | 1 | Gated clock to the converter |
| frame_n | output | 1 | Active-low receive frame to the serial port |

## Verification
The pulse counter and the gate enable are the only internal state, and both show up at the ports quickly. A counter that wraps or is not cleared changes the number of `adc_clk` pulses counted in the next active interval. A gate enable that is out of step shows up within one clock period, as a `frame_n` level that disagrees with the pulse count at the end of a phase. An enable that updates on the wrong edge produces a shortened `adc_clk` high phase, which the pulse-width monitor catches on the first pulse.

// File: rtl/sbg_pkg.sv
`timescale 1ns/1ps
package sbg_pkg;

   typedef enum logic {
      READ_DURING = 1'b0,
      READ_AFTER  = 1'b1
   } read_mode_e;

   // Counter width that can hold the pulse limit itself without wrapping
   function automatic int unsigned count_width(input int unsigned pulses);
      return $clog2(pulses) + 1;
   endfunction

endpackage

// File: rtl/sbg_arm_sel.sv
`timescale 1ns/1ps
module sbg_arm_sel
   import sbg_pkg::*;
(
   input  logic busy_n,
   input  logic read_after,
   output logic arm
);

   read_mode_e mode;

   always_comb begin
      mode = read_mode_e'(read_after);
      if (mode == READ_AFTER) begin
         arm = busy_n;
      end else begin
         arm = ~busy_n;
      end
   end

endmodule

// File: rtl/sbg_burst_counter.sv
`timescale 1ns/1ps
module sbg_burst_counter #(
   parameter int unsigned PULSES = 16,
   parameter int unsigned CW     = 5
) (
   input  logic          clk_in,
   input  logic          rst_n,
   input  logic          arm,
   output logic [CW-1:0] cnt,
   output logic          open_next
);

   localparam logic [CW-1:0] LIMIT = CW'(PULSES);

   logic [CW-1:0] cnt_q;

   // Preload to zero whenever not armed; saturate at the limit
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!arm) begin
         cnt_q <= '0;
      end else if (cnt_q < LIMIT) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign open_next = arm && (cnt_q < LIMIT);
   assign cnt       = cnt_q;

endmodule

// File: rtl/sbg_gate_stage.sv
`timescale 1ns/1ps
module sbg_gate_stage (
   input  logic clk_in,
   input  logic rst_n,
   input  logic open_next,
   output logic adc_clk,
   output logic frame_n
);

   logic gate_q;
   logic frame_q;

   // Enable changes only while clk_in is low, so the AND never clips a pulse
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         gate_q  <= 1'b0;
         frame_q <= 1'b1;
      end else begin
         gate_q  <= open_next;
         frame_q <= ~open_next;
      end
   end

   assign adc_clk = clk_in & gate_q;
   assign frame_n = frame_q;

endmodule

// File: rtl/sclk_burst_gate.sv
`timescale 1ns/1ps
module sclk_burst_gate #(
   parameter int unsigned PULSES = 16
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic busy_n,
   input  logic read_after,
   output logic adc_clk,
   output logic frame_n
);

   localparam int unsigned CW = sbg_pkg::count_width(PULSES);

   if (PULSES < 1) begin : g_bad_pulses
      $error("sclk_burst_gate: PULSES must be at least 1");
   end

   logic          arm_w;
   logic [CW-1:0] cnt_w;
   logic          open_w;

   sbg_arm_sel arm_i (
      .busy_n     (busy_n),
      .read_after (read_after),
      .arm        (arm_w)
   );

   sbg_burst_counter #(
      .PULSES (PULSES),
      .CW     (CW)
   ) cnt_i (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .arm       (arm_w),
      .cnt       (cnt_w),
      .open_next (open_w)
   );

   sbg_gate_stage gate_i (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .open_next (open_w),
      .adc_clk   (adc_clk),
      .frame_n   (frame_n)
   );

endmodule

// File: rtl/sbg_chk.sv
`timescale 1ns/1ps
module sbg_chk #(
   parameter int unsigned PULSES = 16,
   parameter int unsigned CW     = 5
) (
   input logic          clk_in,
   input logic          rst_n,
   input logic          arm,
   input logic [CW-1:0] cnt,
   input logic          adc_clk,
   input logic          frame_n
);

   // R2
   idle_blocks_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      !arm |=> frame_n);

   // R6
   preload_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      !arm |=> (cnt == '0));

   // R4
   no_overflow_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      cnt <= CW'(PULSES));

   // R4
   hold_closed_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      (cnt == CW'(PULSES)) |=> frame_n);

   // R5
   frame_tracks_clk_chk: assert property (@(negedge clk_in) disable iff (!rst_n)
      adc_clk == !frame_n);

endmodule

bind sclk_burst_gate sbg_chk #(
   .PULSES (PULSES),
   .CW     (CW)
) chk_i (
   .clk_in  (clk_in),
   .rst_n   (rst_n),
   .arm     (arm_w),
   .cnt     (cnt_w),
   .adc_clk (adc_clk),
   .frame_n (frame_n)
);

// File: tb/sclk_burst_gate_tb_top.sv
`timescale 1ns/1ps
module sclk_burst_gate_tb_top;

   localparam int N = 16;
   localparam int NVEC = 9;
   // {read_after, idle cycles, busy-low cycles, tail busy-high cycles}
   localparam int VEC [NVEC][4] = '{
      '{0, 4, 40, 5},
      '{0, 3, 16, 4},
      '{0, 3, 10, 4},
      '{0, 2, 17, 3},
      '{0, 3,  1, 3},
      '{1, 5, 30, 40},
      '{1, 5, 20, 8},
      '{1, 5, 20, 16},
      '{1, 3,  5, 1}
   };

   logic clk_in = 1'b1;
   logic rst_n = 1'b0;
   logic busy_n = 1'b0;
   logic read_after = 1'b0;
   logic adc_clk;
   logic frame_n;

   int checks = 0;
   int fails = 0;
   int pulses = 0;
   int runts = 0;
   realtime rise_t = 0;

   always #10 clk_in = ~clk_in;

   sclk_burst_gate #(.PULSES(N)) dut_i (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .busy_n     (busy_n),
      .read_after (read_after),
      .adc_clk    (adc_clk),
      .frame_n    (frame_n)
   );

   always @(posedge adc_clk) begin
      pulses++;
      rise_t = $realtime;
   end

   // R8: each passed high phase must last a full 10 ns
   always @(negedge adc_clk) begin
      if (rst_n && ($realtime - rise_t != 10.0)) runts++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(posedge clk_in);
      #2;
   endtask

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   initial begin
      #(200000 * 20);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset with busy low must keep everything quiet
      hold(1);
      pulses = 0;
      hold(5);
      check("R1 pulses in reset", pulses, 0);
      check("R1 frame_n in reset", int'(frame_n), 1);
      check("R1 adc_clk in reset", int'(adc_clk), 0);

      // R9: release while armed gives a full burst
      rst_n = 1'b1;
      pulses = 0;
      hold(25);
      check("R9 burst after reset", pulses, N);
      check("R9 frame_n after burst", int'(frame_n), 1);

      // Vector table: R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NVEC; v++) begin
         read_after = VEC[v][0][0];
         busy_n = 1'b1;
         hold(VEC[v][1]);
         pulses = 0;
         busy_n = 1'b0;
         hold(VEC[v][2]);
         if (VEC[v][0] == 0) begin
            check("R3/R4/R6 pulses in busy-low", pulses, min2(N, VEC[v][2]));
            check("R5 frame_n end of busy-low", int'(frame_n), (VEC[v][2] <= N) ? 0 : 1);
         end else begin
            check("R7 pulses in busy-low", pulses, 0);
            check("R7 frame_n end of busy-low", int'(frame_n), 1);
         end
         pulses = 0;
         busy_n = 1'b1;
         hold(VEC[v][3]);
         if (VEC[v][0] == 0) begin
            check("R2 pulses in busy-high", pulses, 0);
            check("R2 frame_n busy-high", int'(frame_n), 1);
         end else begin
            check("R7 pulses in busy-high", pulses, min2(N, VEC[v][3]));
            check("R5 frame_n end of busy-high", int'(frame_n), (VEC[v][3] <= N) ? 0 : 1);
         end
      end

      // R1: asynchronous reset in the middle of a burst
      read_after = 1'b0;
      busy_n = 1'b1;
      hold(3);
      busy_n = 1'b0;
      hold(5);
      check("R5 frame_n mid-burst", int'(frame_n), 0);
      rst_n = 1'b0;
      #1;
      check("R1 frame_n after async reset", int'(frame_n), 1);
      check("R1 adc_clk after async reset", int'(adc_clk), 0);
      pulses = 0;
      hold(4);
      check("R1 pulses while held in reset", pulses, 0);
      busy_n = 1'b1;
      rst_n = 1'b1;
      hold(3);
      pulses = 0;
      busy_n = 1'b0;
      hold(30);
      check("R4 full burst after reset cycle", pulses, N);

      check("R8 shortened adc_clk pulses", runts, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule